// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

A watchdog with a small register file. Once armed, it counts upward on a slow tick. It pulses a reset output for one cycle if software fails to service it before the count passes all-ones. The slow tick comes from a strobe at the 32 kHz reference rate, delivered in the system clock domain. A prescaler can divide that tick by a power of two before it reaches the counter.

Software turns the watchdog on and off only with two-word key sequences written to a key register. It services the watchdog by writing the trigger register with a value different from the previous one. Alternating a pattern with its complement is the usual way to do this.

Every register write is posted. A pending flag per register stays visible until the write lands, four reference strobes later. While the watchdog runs, the prescaler setup and the reload value are locked.

Top module: `keyed_wdt`

## Requirements
- R1: Register addresses are 0 setup, 1 reload value, 2 trigger, 3 key, 4 pending flags (read only) and 5 current count (read only). After reset every readable register reads 0, the key register always reads 0, and `wdt_rst` is low.
- R2: A write to address 0, 1, 2 or 3 sets pending bit 0, 1, 2 or 3 of address 4 in the following cycle. The bit stays set, and the written value stays unapplied, until the fourth `ref_tick` strobe after the write cycle. The bit clears and the value applies on that strobe's clock edge. Address 4 reads 0 when nothing is pending.
- R3: A write to a register whose pending bit is still set is dropped.
- R4: A key value of 0xBBBB followed by 0x4444, each counted when its posted write lands, starts the watchdog. It also loads the counter with the reload value.
- R5: A key value of 0xAAAA followed by 0x5555 stops the watchdog. The count then holds its value.
- R6: Any other landed key value ends a partial sequence without changing the running state. A lone second word has no effect.
- R7: While the watchdog runs, landed writes to the setup and reload registers are discarded.
- R8: Setup bit 0 enables the prescaler, and bits 3:1 hold a ratio k. With the prescaler off, a running counter adds one per `ref_tick`. With it on, the counter adds one every 2^k strobes, counted from the start.
- R9: A landed trigger value that differs from the stored one is stored and reloads the counter. A repeated equal value changes nothing.
- R10: When a count step occurs at all-ones, the counter reloads from the reload value. `wdt_rst` is then high for exactly the next cycle.
- R11: While stopped, the counter does not step and `wdt_rst` stays low.
- R12: The setup and reload registers accept writes while the watchdog is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench pins down the exact strobe on which a posted write lands. It reads the value after three strobes and again after four. A design that counts the write-cycle strobe, or applies the value at write time, fails there. It breaks key sequences and sends a lone second word, which catches a state machine that skips the first word or keeps a stale partial state. It repeats a trigger value and also sends its complement, which exposes reload-on-every-write or reload-never designs. It drives the counter through the all-ones wrap with the prescaler at a ratio of two. That shows a missing or stretched reset pulse, a lost reload, and an off-by-one in the divider.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 3;
    localparam int RATIO_W = 3;
    localparam int NUM_POST = 4;
    localparam int DIV_W   = (1 << RATIO_W) - 1;

    localparam logic [ADDR_W-1:0] ADR_SETUP = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_TRIG  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_KEY   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_PEND  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd5;

    localparam int SLOT_SETUP  = 0;
    localparam int SLOT_RELOAD = 1;
    localparam int SLOT_TRIG   = 2;
    localparam int SLOT_KEY    = 3;

    localparam logic [15:0] KEY_HALT_FIRST = 16'hAAAA;
    localparam logic [15:0] KEY_HALT_SECOND = 16'h5555;
    localparam logic [15:0] KEY_ARM_FIRST  = 16'hBBBB;
    localparam logic [15:0] KEY_ARM_SECOND = 16'h4444;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_HALT_HALF,
        SEQ_ARM_HALF
    } seq_state_e;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               pre_on;
    } setup_t;

    function automatic logic key_match(logic [REG_W-1:0] v, logic [15:0] k);
        return v == {{(REG_W-16){1'b0}}, k};
    endfunction

    function automatic logic [DIV_W-1:0] ratio_mask(logic [RATIO_W-1:0] r);
        return DIV_W'((1 << r) - 1);
    endfunction

endpackage

// File: rtl/kw_post_slot.sv
module kw_post_slot
    import keyed_wdt_pkg::*;
#(
    parameter int TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_val,
    output logic             pending,
    output logic             landed,
    output logic [REG_W-1:0] held_val
);
    localparam int LW = $clog2(TICKS + 1);

    logic [LW-1:0] left_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            left_q   <= '0;
            held_val <= '0;
        end else if (wr_stb && !pend_q) begin
            pend_q   <= 1'b1;
            left_q   <= LW'(TICKS);
            held_val <= wr_val;
        end else if (pend_q && ref_tick) begin
            left_q <= left_q - LW'(1);
            if (left_q == LW'(1)) pend_q <= 1'b0;
        end
    end

    assign pending = pend_q;
    assign landed  = pend_q && ref_tick && (left_q == LW'(1));
endmodule

// File: rtl/kw_key_seq.sv
module kw_key_seq
    import keyed_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_landed,
    input  logic [REG_W-1:0] key_val,
    output logic             running,
    output logic             arm_evt
);
    seq_state_e state_q;

    assign arm_evt = key_landed && (state_q == SEQ_ARM_HALF)
                     && key_match(key_val, KEY_ARM_SECOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            running <= 1'b0;
        end else if (key_landed) begin
            case (state_q)
                SEQ_IDLE: begin
                    if (key_match(key_val, KEY_ARM_FIRST))       state_q <= SEQ_ARM_HALF;
                    else if (key_match(key_val, KEY_HALT_FIRST)) state_q <= SEQ_HALT_HALF;
                    else                                         state_q <= SEQ_IDLE;
                end
                SEQ_HALT_HALF: begin
                    if (key_match(key_val, KEY_HALT_SECOND)) running <= 1'b0;
                    state_q <= SEQ_IDLE;
                end
                SEQ_ARM_HALF: begin
                    if (key_match(key_val, KEY_ARM_SECOND)) running <= 1'b1;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/kw_prescale.sv
module kw_prescale
    import keyed_wdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ref_tick,
    input  logic   running,
    input  setup_t setup,
    output logic   step
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    assign lim  = ratio_mask(setup.ratio);
    assign wrap = (div_q == lim);
    assign step = running && ref_tick && (!setup.pre_on || wrap);

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            div_q <= '0;
        end else if (ref_tick) begin
            div_q <= wrap ? '0 : div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/kw_counter.sv
module kw_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (reload) begin
                count <= reload_val;
            end else if (step) begin
                if (&count) begin
                    count  <= reload_val;
                    expire <= 1'b1;
                end else begin
                    count <= count + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int POST_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              wdt_rst
);
    logic [NUM_POST-1:0] pend_vec;
    logic [NUM_POST-1:0] land_vec;
    logic [REG_W-1:0]    held [NUM_POST];

    setup_t              setup_q;
    logic [CNT_W-1:0]    load_q;
    logic [REG_W-1:0]    trig_q;
    logic                running;
    logic                arm_evt;
    logic                step;
    logic                trig_reload;
    logic [CNT_W-1:0]    count;

    for (genvar i = 0; i < NUM_POST; i++) begin : g_post
        kw_post_slot #(.TICKS(POST_TICKS)) slot_i (
            .clk      (clk),
            .rst      (rst),
            .ref_tick (ref_tick),
            .wr_stb   (wr_en && (wr_addr == ADDR_W'(i))),
            .wr_val   (wr_data),
            .pending  (pend_vec[i]),
            .landed   (land_vec[i]),
            .held_val (held[i])
        );
    end

    assign trig_reload = land_vec[SLOT_TRIG] && (held[SLOT_TRIG] != trig_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '0;
            load_q  <= '0;
            trig_q  <= '0;
        end else begin
            if (land_vec[SLOT_SETUP] && !running)
                setup_q <= setup_t'(held[SLOT_SETUP][RATIO_W:0]);
            if (land_vec[SLOT_RELOAD] && !running)
                load_q <= held[SLOT_RELOAD][CNT_W-1:0];
            if (trig_reload)
                trig_q <= held[SLOT_TRIG];
        end
    end

    kw_key_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .key_landed (land_vec[SLOT_KEY]),
        .key_val    (held[SLOT_KEY]),
        .running    (running),
        .arm_evt    (arm_evt)
    );

    kw_prescale pre_i (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .running  (running),
        .setup    (setup_q),
        .step     (step)
    );

    kw_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .reload     (trig_reload || arm_evt),
        .reload_val (load_q),
        .count      (count),
        .expire     (wdt_rst)
    );

    always_comb begin
        case (rd_addr)
            ADR_SETUP:  rd_data = REG_W'(setup_q);
            ADR_RELOAD: rd_data = REG_W'(load_q);
            ADR_TRIG:   rd_data = trig_q;
            ADR_PEND:   rd_data = REG_W'(pend_vec);
            ADR_COUNT:  rd_data = REG_W'(count);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                ref_tick,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                wdt_rst,
    input logic                running,
    input logic [NUM_POST-1:0] status,
    input logic [RATIO_W:0]    setup_bits,
    input logic [CNT_W-1:0]    load_val,
    input logic [CNT_W-1:0]    count
);
    AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == ADR_RELOAD) |=> status[SLOT_RELOAD]); // R2

    AST_PEND_CLEARS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (|($past(status) & ~status)) |-> $past(ref_tick)); // R2

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $past(running) && running |-> $stable(load_val) && $stable(setup_bits)); // R7

    AST_RST_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> $past(running)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(!running) && !running && !$past(status[SLOT_TRIG]) |-> $stable(count)); // R11
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ref_tick   (ref_tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wdt_rst    (wdt_rst),
    .running    (running),
    .status     (pend_vec),
    .setup_bits (setup_q),
    .load_val   (load_q),
    .count      (count)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wdt_rst;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    bit finished = 1'b0;

    typedef struct {
        int          tag;
        bit          is_pulse;
        logic [2:0]  addr;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    keyed_wdt dut_i (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst(wdt_rst)
    );

    always @(posedge clk) if (!rst && wdt_rst) pulse_cnt++;

    // monitor: pops expected items and compares against the design
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        if (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            act = it.is_pulse ? 32'(pulse_cnt) : rd_data;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL R%0d addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic expect_rd(input int tag, input logic [2:0] a, input logic [31:0] e);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        @(posedge clk);
        it.tag = tag; it.is_pulse = 1'b0; it.addr = a; it.exp = e;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_pulses(input int tag, input int e);
        item_t it;
        @(posedge clk);
        it.tag = tag; it.is_pulse = 1'b1; it.addr = 3'd0; it.exp = 32'(e);
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    localparam logic [31:0] LD = 32'hFFFF_FFF0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_rd(1, 3'd4, 32'h0);
        expect_rd(1, 3'd5, 32'h0);
        expect_rd(1, 3'd0, 32'h0);
        expect_rd(1, 3'd1, 32'h0);
        expect_pulses(1, 0);
        // R2 posted reload write, lands on fourth strobe
        wr(3'd1, LD);
        expect_rd(2, 3'd4, 32'h2);
        slow(3);
        expect_rd(2, 3'd4, 32'h2);
        expect_rd(2, 3'd1, 32'h0);
        slow(1);
        expect_rd(2, 3'd4, 32'h0);
        expect_rd(2, 3'd1, LD);
        // R12 setup accepted while stopped: prescaler on, ratio 1
        wr(3'd0, 32'h3);
        slow(4);
        expect_rd(12, 3'd0, 32'h3);
        // R11 stopped counter holds
        slow(5);
        expect_rd(11, 3'd5, 32'h0);
        // R6 broken sequence and lone second word
        wr(3'd3, 32'hBBBB);
        expect_rd(2, 3'd4, 32'h8);
        slow(4);
        wr(3'd3, 32'h1234); slow(4);
        wr(3'd3, 32'h4444); slow(4);
        slow(2);
        expect_rd(6, 3'd5, 32'h0);
        expect_pulses(6, 0);
        // R4 arm sequence loads counter
        wr(3'd3, 32'hBBBB); slow(4);
        wr(3'd3, 32'h4444); slow(4);
        expect_rd(4, 3'd5, LD);
        // R8 divide by two
        slow(4);
        expect_rd(8, 3'd5, LD + 2);
        // R7 config frozen while running
        wr(3'd1, 32'h100); slow(4);
        expect_rd(7, 3'd1, LD);
        wr(3'd0, 32'h0); slow(4);
        expect_rd(7, 3'd0, 32'h3);
        // R9 changed trigger reloads
        wr(3'd2, 32'h1234); slow(4);
        expect_rd(9, 3'd5, LD);
        expect_rd(9, 3'd2, 32'h1234);
        wr(3'd2, 32'h1234); slow(4);
        expect_rd(9, 3'd5, LD + 2);
        wr(3'd2, 32'hFFFF_EDCB); slow(4);
        expect_rd(9, 3'd5, LD);
        // R3 write while pending is dropped
        wr(3'd2, 32'hA);
        wr(3'd2, 32'hB);
        slow(4);
        expect_rd(3, 3'd2, 32'hA);
        expect_rd(3, 3'd5, LD);
        // R10 overflow: 16 steps, 32 strobes
        slow(31);
        expect_rd(10, 3'd5, 32'hFFFF_FFFF);
        expect_pulses(10, 0);
        slow(1);
        expect_pulses(10, 1);
        expect_rd(10, 3'd5, LD);
        slow(2);
        expect_pulses(10, 1);
        expect_rd(10, 3'd5, LD + 1);
        // R5 halt sequence
        wr(3'd3, 32'hAAAA); slow(4);
        wr(3'd3, 32'h5555); slow(4);
        expect_rd(5, 3'd5, LD + 5);
        slow(4);
        expect_rd(5, 3'd5, LD + 5);
        // R12 reload accepted when stopped; R8 prescaler off
        wr(3'd1, 32'h20); slow(4);
        expect_rd(12, 3'd1, 32'h20);
        wr(3'd0, 32'h0); slow(4);
        wr(3'd3, 32'hBBBB); slow(4);
        wr(3'd3, 32'h4444); slow(4);
        expect_rd(4, 3'd5, 32'h20);
        slow(3);
        expect_rd(8, 3'd5, 32'h23);
        expect_pulses(11, 1);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule